// File: doc/BRIEF.md
# Reset Handshake Sequencer with Sticky Timeout Log

This block runs just before a hardware-sequenced warm or watchdog reset. When `seq_req` is raised, it sends a handshake (or stall) request to each downstream agent that takes part. The agents are a memory controller, an FPGA handshake, a trace router that must stall its AXI master port, four FPGA/SoC bridge ports, and an interconnect. The block then waits until each request has either been acknowledged or has run out of time. Only then does it raise `reset_go`, which lets the reset tree proceed. An agent that never answers cannot block the reset.

Every handshake that times out sets its own bit in a 32-bit sticky status word, which software reads on `csr_rdata`. Software clears a bit by writing a 1 to it. A cold reset clears the whole word. A warm reset only returns the sequencer to idle and keeps the log, so the cause of a slow reset can still be read once the warm reset has finished.

The sequencer has three states:
- `ST_IDLE`: waits for `seq_req`. Moves to `ST_SHAKE` when `seq_req` is 1.
- `ST_SHAKE`: requests are outstanding. Moves to `ST_GO` once every enabled agent has resolved, either by acknowledge or by timeout.
- `ST_GO`: drives `reset_go`. Returns to `ST_IDLE` when `seq_req` falls.

An active-low `warm_rst_n` or `cold_rst_n` forces `ST_IDLE` from any state.

Top module: `rst_handshake_seq`

## Requirements
- R1: In the cycle after `seq_req` is sampled high in idle, `hs_req` is high for every enabled agent. Agent index i maps to status bit: 0→0, 1→2, 2→3, 3→9, 4→10, 5→11, 6→12, 7→16, 8→17. Agents 0 to 6 are always enabled.
- R2: An acknowledge sampled while an agent's request is high drops that request at the next edge, and sets no status bit.
- R3: A request that sees no acknowledge for `TIMEOUT_CYCLES` consecutive cycles drops after that many cycles and sets the agent's status bit.
- R4: `reset_go` rises at the second edge after the last request resolves; with every enabled agent acknowledging at once, that is the third edge counted from the one that samples `seq_req`. `hs_req` is all zero while `reset_go` is high, and `reset_go` falls at the edge after `seq_req` is sampled low.
- R5: With `keep_dbg`=1 (interconnect reset, debug kept alive), agent 7 (bit 16) is enabled and agent 8 (bit 17) is not. With `keep_dbg`=0, agent 8 is enabled and agent 7 is not.
- R6: Status bits are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R7: If a timeout and a write-one-to-clear hit the same bit at the same edge, the bit ends at 1.
- R8: All bits outside {0,2,3,9,10,11,12,16,17} always read 0, and writes to them have no effect.
- R9: A low `cold_rst_n` clears every status bit. A low `warm_rst_n` drops all requests and `reset_go` but leaves the status bits unchanged.
- R10: An acknowledge while no request is outstanding has no effect on requests, `reset_go` or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Asynchronous cold reset, active low; clears the status word |
| warm_rst_n | input | 1 | Asynchronous warm reset, active low; resets the sequencer only |
| seq_req | input | 1 | Request to run the pre-reset handshakes; held until reset proceeds |
| keep_dbg | input | 1 | 1 when the interconnect is reset while debug logic stays alive |
| hs_ack | input | 9 | Acknowledge from each agent |
| hs_req | output | 9 | Handshake/stall request to each agent |
| reset_go | output | 1 | All handshakes resolved; reset may proceed |
| csr_wr | input | 1 | Status write strobe (write-one-to-clear) |
| csr_wdata | input | 32 | Status write data |
| csr_rdata | output | 32 | Status word |

## Verification
The bound checker enforces several properties on every cycle:
- reserved bits stay zero;
- no request is ever high together with `reset_go`;
- `reset_go` never follows a cycle in which a request was still outstanding;
- a status bit can fall only after a write;
- warm reset silences requests and `reset_go`.

Exact timing needs the bench's scenarios: the timeout length, the latency to `reset_go`, which bits each mix of answering and silent agents leaves set, and the two debug modes. The same holds for a set colliding with a clear, and for the log surviving a warm reset but not a cold one.

// File: rtl/rsths_pkg.sv
package rsths_pkg;

    localparam int unsigned NUM_AGENTS = 9;
    localparam int unsigned STATUS_W   = 32;

    // agents whose participation depends on keep_dbg
    localparam int unsigned IDX_NOC_KEEP = 7;
    localparam int unsigned IDX_NOC_FULL = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHAKE = 2'd1,
        ST_GO    = 2'd2
    } seq_state_e;

    // status bit position logged for each agent index
    function automatic int unsigned agent_bit(input int unsigned idx);
        case (idx)
            0:       agent_bit = 0;
            1:       agent_bit = 2;
            2:       agent_bit = 3;
            3:       agent_bit = 9;
            4:       agent_bit = 10;
            5:       agent_bit = 11;
            6:       agent_bit = 12;
            7:       agent_bit = 16;
            default: agent_bit = 17;
        endcase
    endfunction

    function automatic logic [STATUS_W-1:0] log_mask();
        logic [STATUS_W-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < NUM_AGENTS; i++) begin
            m[agent_bit(i)] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/rsths_agent.sv
module rsths_agent #(
    parameter int unsigned TIMEOUT_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic active,
    input  logic enable,
    input  logic ack,
    output logic req,
    output logic timeout_evt,
    output logic resolved
);

    localparam int unsigned CNT_W = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TIMEOUT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (launch) begin
            cnt_q  <= CNT_LOAD;
            done_q <= !enable;
        end else if (req) begin
            if (ack || cnt_q == '0) begin
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        req         = active && !done_q;
        timeout_evt = req && !ack && (cnt_q == '0);
        resolved    = done_q;
    end

endmodule

// File: rtl/rsths_fsm.sv
module rsths_fsm
    import rsths_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic seq_req,
    input  logic all_resolved,
    output logic launch,
    output logic shaking,
    output logic reset_go
);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (seq_req)      state_d = ST_SHAKE;
            ST_SHAKE: if (all_resolved) state_d = ST_GO;
            ST_GO:    if (!seq_req)     state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        launch   = (state_q == ST_IDLE) && seq_req;
        shaking  = (state_q == ST_SHAKE);
        reset_go = (state_q == ST_GO);
    end

endmodule

// File: rtl/rsths_status.sv
module rsths_status
    import rsths_pkg::*;
(
    input  logic                clk,
    input  logic                cold_rst_n,
    input  logic [STATUS_W-1:0] set_vec,
    input  logic                wr,
    input  logic [STATUS_W-1:0] wdata,
    output logic [STATUS_W-1:0] status
);

    localparam logic [STATUS_W-1:0] LOG_MASK = log_mask();

    for (genvar b = 0; b < STATUS_W; b++) begin : g_bit
        if (LOG_MASK[b]) begin : g_sticky
            logic bit_q;
            always_ff @(posedge clk or negedge cold_rst_n) begin
                if (!cold_rst_n) begin
                    bit_q <= 1'b0;
                end else begin
                    // a hardware set takes priority over a clear in the same cycle
                    bit_q <= set_vec[b] || (bit_q && !(wr && wdata[b]));
                end
            end
            assign status[b] = bit_q;
        end else begin : g_rsvd
            assign status[b] = 1'b0;
        end
    end

endmodule

// File: rtl/rst_handshake_seq.sv
module rst_handshake_seq
    import rsths_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 64
) (
    input  logic                  clk,
    input  logic                  cold_rst_n,
    input  logic                  warm_rst_n,
    input  logic                  seq_req,
    input  logic                  keep_dbg,
    input  logic [NUM_AGENTS-1:0] hs_ack,
    output logic [NUM_AGENTS-1:0] hs_req,
    output logic                  reset_go,
    input  logic                  csr_wr,
    input  logic [STATUS_W-1:0]   csr_wdata,
    output logic [STATUS_W-1:0]   csr_rdata
);

    logic                  seq_rst_n;
    logic                  launch;
    logic                  shaking;
    logic                  all_resolved;
    logic [NUM_AGENTS-1:0] agent_en;
    logic [NUM_AGENTS-1:0] tmo_evt;
    logic [NUM_AGENTS-1:0] resolved;
    logic [STATUS_W-1:0]   set_vec;

    assign seq_rst_n = cold_rst_n & warm_rst_n;

    always_comb begin
        agent_en               = '1;
        agent_en[IDX_NOC_KEEP] = keep_dbg;
        agent_en[IDX_NOC_FULL] = !keep_dbg;
    end

    rsths_fsm u_fsm (
        .clk          (clk),
        .rst_n        (seq_rst_n),
        .seq_req      (seq_req),
        .all_resolved (all_resolved),
        .launch       (launch),
        .shaking      (shaking),
        .reset_go     (reset_go)
    );

    for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_agent
        rsths_agent #(
            .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
        ) u_agent (
            .clk         (clk),
            .rst_n       (seq_rst_n),
            .launch      (launch),
            .active      (shaking),
            .enable      (agent_en[i]),
            .ack         (hs_ack[i]),
            .req         (hs_req[i]),
            .timeout_evt (tmo_evt[i]),
            .resolved    (resolved[i])
        );
    end

    assign all_resolved = &resolved;

    always_comb begin
        set_vec = '0;
        for (int unsigned i = 0; i < NUM_AGENTS; i++) begin
            set_vec[agent_bit(i)] = tmo_evt[i];
        end
    end

    rsths_status u_status (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .set_vec    (set_vec),
        .wr         (csr_wr),
        .wdata      (csr_wdata),
        .status     (csr_rdata)
    );

endmodule

module rsths_checker
    import rsths_pkg::*;
(
    input logic                  clk,
    input logic                  cold_rst_n,
    input logic                  warm_rst_n,
    input logic [NUM_AGENTS-1:0] hs_req,
    input logic                  reset_go,
    input logic                  csr_wr,
    input logic [STATUS_W-1:0]   csr_rdata
);

    localparam logic [STATUS_W-1:0] LOG_MASK = log_mask();

    assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (csr_rdata & ~LOG_MASK) == '0);

    assert_go_quiet_R4: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
        reset_go |-> (hs_req == '0));

    assert_go_after_resolve_R4: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
        (hs_req != '0) |=> !reset_go);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !csr_wr |=> ((csr_rdata & $past(csr_rdata)) == $past(csr_rdata)));

    assert_warm_idle_R9: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !warm_rst_n |-> (hs_req == '0 && !reset_go));

endmodule

bind rst_handshake_seq rsths_checker u_rsths_checker (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .warm_rst_n (warm_rst_n),
    .hs_req     (hs_req),
    .reset_go   (reset_go),
    .csr_wr     (csr_wr),
    .csr_rdata  (csr_rdata)
);

// File: tb/test_rst_handshake_seq.sv
module test_rst_handshake_seq;

    localparam int unsigned TMO = 6;

    logic        clk = 1'b0;
    logic        cold_rst_n = 1'b0;
    logic        warm_rst_n = 1'b1;
    logic        seq_req = 1'b0;
    logic        keep_dbg = 1'b0;
    logic [8:0]  hs_ack = '0;
    logic [8:0]  hs_req;
    logic        reset_go;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rst_handshake_seq #(.TIMEOUT_CYCLES(TMO)) i_rst_handshake_seq (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .warm_rst_n (warm_rst_n),
        .seq_req    (seq_req),
        .keep_dbg   (keep_dbg),
        .hs_ack     (hs_ack),
        .hs_req     (hs_req),
        .reset_go   (reset_go),
        .csr_wr     (csr_wr),
        .csr_wdata  (csr_wdata),
        .csr_rdata  (csr_rdata)
    );

    // {keep_dbg, ack pattern, expected status}
    localparam logic [41:0] VEC [5] = '{
        {1'b0, 9'h1FF, 32'h0000_0000},
        {1'b0, 9'h000, 32'h0002_1E0D},
        {1'b1, 9'h000, 32'h0001_1E0D},
        {1'b0, 9'h0AA, 32'h0002_1409},
        {1'b1, 9'h155, 32'h0001_0A04}
    };

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [8:0] en_mask(input logic keep);
        return keep ? 9'h0FF : 9'h17F;
    endfunction

    task automatic write_status(input logic [31:0] d);
        @(negedge clk);
        csr_wr = 1'b1;
        csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
        csr_wdata = '0;
    endtask

    task automatic run_seq(input logic keep, input logic [8:0] ack,
                           output int edges, output logic [8:0] req0);
        @(negedge clk);
        keep_dbg = keep;
        hs_ack = ack;
        seq_req = 1'b1;
        @(posedge clk);
        edges = 1;
        @(negedge clk);
        req0 = hs_req;
        while (!reset_go && edges < 100) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
    endtask

    task automatic finish_seq();
        @(negedge clk);
        seq_req = 1'b0;
        hs_ack = '0;
        @(negedge clk);
        check("R4 reset_go falls after seq_req drops", {31'd0, reset_go}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int edges;
        logic [8:0] req0;

        repeat (3) @(negedge clk);
        check("R9 reset hs_req", {23'd0, hs_req}, 32'd0);
        check("R9 reset reset_go", {31'd0, reset_go}, 32'd0);
        check("R9 reset status", csr_rdata, 32'd0);
        cold_rst_n = 1'b1;

        // R10: acknowledges while idle do nothing
        @(negedge clk);
        hs_ack = 9'h1FF;
        repeat (3) @(negedge clk);
        check("R10 idle ack hs_req", {23'd0, hs_req}, 32'd0);
        check("R10 idle ack reset_go", {31'd0, reset_go}, 32'd0);
        check("R10 idle ack status", csr_rdata, 32'd0);
        hs_ack = '0;

        // table-driven sequences: R1 R2 R3 R4 R5
        for (int v = 0; v < 5; v++) begin
            logic       k;
            logic [8:0] a;
            logic [31:0] e;
            int         exp_edges;
            {k, a, e} = VEC[v];
            exp_edges = (((~a) & en_mask(k)) != 9'h000) ? int'(TMO) + 2 : 3;
            run_seq(k, a, edges, req0);
            check("R1 R5 requests raised", {23'd0, req0}, {23'd0, en_mask(k)});
            check("R4 R3 reset_go latency", edges, exp_edges);
            check("R3 R2 logged status", csr_rdata, e);
            check("R4 requests low in go", {23'd0, hs_req}, 32'd0);
            finish_seq();
            if (v != 4) write_status(32'hFFFF_FFFF);
        end

        // R6: writing 0 keeps, writing 1 clears
        write_status(32'h0);
        check("R6 write 0 no effect", csr_rdata, 32'h0001_0A04);
        write_status(32'h0000_0004);
        check("R6 write 1 clears bit 2", csr_rdata, 32'h0001_0A00);
        write_status(32'hFFFF_FFFF);
        check("R8 R6 clear all, reserved ignored", csr_rdata, 32'h0);

        // R2: late acknowledge inside the window logs nothing
        @(negedge clk);
        keep_dbg = 1'b0;
        hs_ack = 9'h1FE;
        seq_req = 1'b1;
        @(posedge clk);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R2 agent0 still requesting", {31'd0, hs_req[0]}, 32'd1);
        hs_ack = 9'h1FF;
        @(negedge clk);
        check("R2 request dropped after ack", {31'd0, hs_req[0]}, 32'd0);
        repeat (2) @(negedge clk);
        check("R2 reset_go after late ack", {31'd0, reset_go}, 32'd1);
        check("R2 no status after late ack", csr_rdata, 32'd0);
        finish_seq();

        // R7: timeout set collides with write-one-to-clear
        @(negedge clk);
        keep_dbg = 1'b0;
        hs_ack = 9'h1FE;
        seq_req = 1'b1;
        @(posedge clk);
        repeat (TMO - 1) @(posedge clk);
        @(negedge clk);
        csr_wr = 1'b1;
        csr_wdata = 32'h0000_0001;
        @(negedge clk);
        csr_wr = 1'b0;
        csr_wdata = '0;
        check("R7 set wins over clear", csr_rdata, 32'h0000_0001);
        repeat (2) @(negedge clk);
        finish_seq();

        // R9: warm reset mid-handshake keeps status
        @(negedge clk);
        keep_dbg = 1'b1;
        hs_ack = 9'h000;
        seq_req = 1'b1;
        @(negedge clk);
        check("R5 keep_dbg request set", {23'd0, hs_req}, 32'h0FF);
        warm_rst_n = 1'b0;
        @(negedge clk);
        check("R9 warm drops requests", {23'd0, hs_req}, 32'd0);
        check("R9 warm no reset_go", {31'd0, reset_go}, 32'd0);
        check("R9 warm keeps status", csr_rdata, 32'h0000_0001);
        seq_req = 1'b0;
        @(negedge clk);
        warm_rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 status after warm release", csr_rdata, 32'h0000_0001);

        cold_rst_n = 1'b0;
        @(negedge clk);
        check("R9 cold clears status", csr_rdata, 32'd0);
        cold_rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule